// File: doc/BRIEF.md
# Priority-Based Vectored Interrupt Controller

This block gathers 128 interrupt request sources and presents the processor with a single request line and the 9-bit vector of the source that should be served next. Every source carries a 4-bit priority written by software. Among pending sources the highest priority wins, and equal priorities resolve toward the lowest source number. A request only reaches the processor when the winning priority is strictly above the current-priority register. Software can raise that register to hold off preemption between tasks that share a resource.

Sources 0 to 7 are software flags, set and cleared through the write port. Sources 8 to 127 come from peripheral lines. When the processor acknowledges a request, the block records the vector and saves the running priority on a 16-entry stack. It then lifts the current priority to the level of the acknowledged source. An end-of-interrupt write brings back the saved level. A non-maskable input is passed straight through to a separate critical-interrupt output and never goes through arbitration.

Top module: `vec_irq_ctrl`

## Requirements
- R1: There are 128 sources. The vector of source n is n as a 9-bit value. Source n for n from 8 to 127 is hw_irq[n-8], and sources 0 to 7 are the software flags.
- R2: A write with wr_kind=2 sets software flag wr_idx[2:0]. A write with wr_kind=3 clears it. A set flag requests exactly like a peripheral line.
- R3: A write with wr_kind=0 sets the priority of source wr_idx to wr_data. All priorities are 0 after reset.
- R4: The pending source with the highest priority wins. Among sources of equal priority, the lowest index wins.
- R5: irq_req is high only when the winning priority is strictly greater than cur_prio. A write with wr_kind=1 loads cur_prio from wr_data. cur_prio changes only on a write or an acknowledge.
- R6: nmi_out follows nmi_in in the same cycle, whatever the priorities, the mask and the stack state.
- R7: When irq_ack is high at an edge and irq_req is high, that edge does three things: ack_vec takes irq_vec, the old cur_prio is pushed, and cur_prio takes the priority of the winner.
- R8: A write with wr_kind=4 (end of interrupt) pops the stack into cur_prio. With the stack empty, it leaves cur_prio unchanged.
- R9: A source with priority 0 never raises irq_req, even when cur_prio is 0.
- R10: After reset, irq_req, irq_vec, ack_vec and cur_prio are all 0. irq_req and irq_vec show the inputs that were sampled at the previous clock edge.
- R11: The stack holds 16 levels. An acknowledge while 16 levels are held changes neither cur_prio nor ack_vec. The saved levels come back in reverse order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hw_irq | input | 120 | Peripheral request lines for sources 8..127 |
| wr_en | input | 1 | Register write strobe |
| wr_kind | input | 3 | Write type: 0 priority, 1 current priority, 2 flag set, 3 flag clear, 4 end of interrupt |
| wr_idx | input | 7 | Source index for the write |
| wr_data | input | 4 | Priority value for the write |
| irq_ack | input | 1 | Processor acknowledge |
| nmi_in | input | 1 | Non-maskable request input |
| irq_req | output | 1 | Interrupt request to the processor |
| irq_vec | output | 9 | Vector of the winning source |
| ack_vec | output | 9 | Vector captured at the last accepted acknowledge |
| cur_prio | output | 4 | Current priority level |
| nmi_out | output | 1 | Critical interrupt output |

## Verification
A change on a request line, a flag, a priority or cur_prio shows up on irq_req and irq_vec one edge after the register holding it is updated. The bench drives stimulus at a falling edge. For hw_irq it samples at the next falling edge, and it first checks at the same falling edge that the output has not moved yet. A write updates its register at the next rising edge, so the bench waits one more falling edge before it checks the arbitration result. An acknowledge or end-of-interrupt write changes cur_prio and ack_vec at the single rising edge inside the strobe, and the bench samples them at the falling edge that ends the strobe. nmi_out is combinational and is checked one nanosecond after nmi_in moves.

// File: rtl/vic_pkg.sv
// Shared definitions for the vectored interrupt controller.
// Assumes the write port carries a 3-bit kind code.
package vic_pkg;
    typedef enum logic [2:0] {
        WK_PRIO  = 3'd0,
        WK_CUR   = 3'd1,
        WK_SWSET = 3'd2,
        WK_SWCLR = 3'd3,
        WK_EOI   = 3'd4
    } wr_kind_e;
endpackage

// File: rtl/vic_src_regs.sv
// Source register file: holds the priority of each source and the software flags.
// It merges the flags with the peripheral lines and outputs an effective priority
// per source, which is 0 when the source is idle.
// Assumes SW_SRC is a power of two and at least 2; flags occupy sources 0..SW_SRC-1.
module vic_src_regs
    import vic_pkg::*;
#(
    parameter int NUM_SRC = 128,
    parameter int SW_SRC  = 8,
    parameter int PRIO_W  = 4,
    parameter int IDX_W   = $clog2(NUM_SRC)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [2:0]                wr_kind,
    input  logic [IDX_W-1:0]          wr_idx,
    input  logic [PRIO_W-1:0]         wr_data,
    input  logic [NUM_SRC-SW_SRC-1:0] hw_irq,
    output logic [NUM_SRC*PRIO_W-1:0] eff_prio
);
    localparam int SW_W = $clog2(SW_SRC);

    logic [PRIO_W-1:0] prio_q [NUM_SRC];
    logic [SW_SRC-1:0] sw_q;

    // Priority table update on priority writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_SRC; i++) prio_q[i] <= '0;
        end else if (wr_en && wr_kind == WK_PRIO) begin
            prio_q[wr_idx] <= wr_data;
        end
    end

    // Software flag set and clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sw_q <= '0;
        end else if (wr_en && wr_kind == WK_SWSET) begin
            sw_q[wr_idx[SW_W-1:0]] <= 1'b1;
        end else if (wr_en && wr_kind == WK_SWCLR) begin
            sw_q[wr_idx[SW_W-1:0]] <= 1'b0;
        end
    end

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        if (g < SW_SRC) begin : g_sw
            assign eff_prio[g*PRIO_W +: PRIO_W] = sw_q[g] ? prio_q[g] : '0;
        end else begin : g_hw
            assign eff_prio[g*PRIO_W +: PRIO_W] = hw_irq[g-SW_SRC] ? prio_q[g] : '0;
        end
    end
endmodule

// File: rtl/vic_arb.sv
// Arbiter: a balanced binary max tree over the effective priorities.
// On a tie the left (lower-index) side wins. An idle source carries priority 0.
// Assumes NUM_SRC is a power of two; the logic depth is log2(NUM_SRC) compare stages.
module vic_arb #(
    parameter int NUM_SRC = 128,
    parameter int PRIO_W  = 4,
    parameter int IDX_W   = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC*PRIO_W-1:0] eff_prio,
    output logic [PRIO_W-1:0]         best_prio,
    output logic [IDX_W-1:0]          best_idx
);
    localparam int NODES = 2*NUM_SRC - 1;

    logic [PRIO_W-1:0] node_p [NODES];
    logic [IDX_W-1:0]  node_i [NODES];

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_leaf
        assign node_p[NUM_SRC-1+g] = eff_prio[g*PRIO_W +: PRIO_W];
        assign node_i[NUM_SRC-1+g] = IDX_W'(g);
    end

    for (genvar g = 0; g < NUM_SRC-1; g++) begin : g_node
        logic take_right;
        assign take_right = node_p[2*g+2] > node_p[2*g+1];
        assign node_p[g]  = take_right ? node_p[2*g+2] : node_p[2*g+1];
        assign node_i[g]  = take_right ? node_i[2*g+2] : node_i[2*g+1];
    end

    assign best_prio = node_p[0];
    assign best_idx  = node_i[0];
endmodule

// File: rtl/vic_prio_ctx.sv
// Priority context: the current-priority register plus a LIFO of saved levels.
// Precedence within one cycle is push, then pop, then direct load.
// A push is refused when the stack is full; a pop does nothing when it is empty.
module vic_prio_ctx #(
    parameter int PRIO_W = 4,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [PRIO_W-1:0] push_prio,
    input  logic              pop,
    input  logic              load,
    input  logic [PRIO_W-1:0] load_prio,
    output logic [PRIO_W-1:0] cur_prio,
    output logic              full
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int SP_W  = $clog2(DEPTH+1);

    logic [PRIO_W-1:0] stk [DEPTH];
    logic [SP_W-1:0]   sp;
    logic [SP_W-1:0]   sp_dec;

    assign full   = (sp == SP_W'(DEPTH));
    assign sp_dec = sp - SP_W'(1);

    // Current level and stack pointer update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_prio <= '0;
            sp       <= '0;
        end else if (push && !full) begin
            cur_prio <= push_prio;
            sp       <= sp + SP_W'(1);
        end else if (pop && sp != '0) begin
            cur_prio <= stk[sp_dec[PTR_W-1:0]];
            sp       <= sp_dec;
        end else if (load) begin
            cur_prio <= load_prio;
        end
    end

    // Stack storage; the entries need no reset because sp guards every read.
    always_ff @(posedge clk) begin
        if (push && !full) stk[sp[PTR_W-1:0]] <= cur_prio;
    end
endmodule

// File: rtl/vec_irq_ctrl.sv
// Top level of the vectored interrupt controller. It registers the arbitration
// result (request, vector, winning level) and handles acknowledge and end of
// interrupt through the priority context. The NMI path goes straight through.
// Assumes that irq_ack is pulsed for a single cycle per acknowledge.
module vec_irq_ctrl
    import vic_pkg::*;
#(
    parameter int NUM_SRC = 128,
    parameter int SW_SRC  = 8,
    parameter int PRIO_W  = 4,
    parameter int VEC_W   = 9,
    parameter int DEPTH   = 16,
    parameter int IDX_W   = $clog2(NUM_SRC)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_SRC-SW_SRC-1:0] hw_irq,
    input  logic                      wr_en,
    input  logic [2:0]                wr_kind,
    input  logic [IDX_W-1:0]          wr_idx,
    input  logic [PRIO_W-1:0]         wr_data,
    input  logic                      irq_ack,
    input  logic                      nmi_in,
    output logic                      irq_req,
    output logic [VEC_W-1:0]          irq_vec,
    output logic [VEC_W-1:0]          ack_vec,
    output logic [PRIO_W-1:0]         cur_prio,
    output logic                      nmi_out
);
    logic [NUM_SRC*PRIO_W-1:0] eff_prio;
    logic [PRIO_W-1:0]         best_prio;
    logic [IDX_W-1:0]          best_idx;
    logic [PRIO_W-1:0]         win_prio_q;
    logic                      stk_full;
    logic                      ack_fire;

    vic_src_regs #(
        .NUM_SRC(NUM_SRC), .SW_SRC(SW_SRC), .PRIO_W(PRIO_W), .IDX_W(IDX_W)
    ) u_src (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_kind(wr_kind),
        .wr_idx(wr_idx), .wr_data(wr_data), .hw_irq(hw_irq), .eff_prio(eff_prio)
    );

    vic_arb #(
        .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .IDX_W(IDX_W)
    ) u_arb (
        .eff_prio(eff_prio), .best_prio(best_prio), .best_idx(best_idx)
    );

    assign ack_fire = irq_ack && irq_req && !stk_full;

    vic_prio_ctx #(
        .PRIO_W(PRIO_W), .DEPTH(DEPTH)
    ) u_ctx (
        .clk(clk), .rst_n(rst_n),
        .push(ack_fire), .push_prio(win_prio_q),
        .pop(wr_en && wr_kind == WK_EOI),
        .load(wr_en && wr_kind == WK_CUR), .load_prio(wr_data),
        .cur_prio(cur_prio), .full(stk_full)
    );

    // Register the arbitration result against the current level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_req    <= 1'b0;
            irq_vec    <= '0;
            win_prio_q <= '0;
        end else begin
            irq_req    <= best_prio > cur_prio;
            irq_vec    <= VEC_W'(best_idx);
            win_prio_q <= best_prio;
        end
    end

    // Capture the served vector on an accepted acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) ack_vec <= '0;
        else if (ack_fire) ack_vec <= irq_vec;
    end

    assign nmi_out = nmi_in;
endmodule

// File: rtl/vic_checker.sv
// Property checker for vec_irq_ctrl, attached through bind.
module vic_checker #(
    parameter int NUM_SRC = 128,
    parameter int PRIO_W  = 4,
    parameter int VEC_W   = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              irq_req,
    input logic [VEC_W-1:0]  irq_vec,
    input logic              irq_ack,
    input logic [VEC_W-1:0]  ack_vec,
    input logic [PRIO_W-1:0] cur_prio,
    input logic              wr_en,
    input logic [PRIO_W-1:0] win_prio,
    input logic              stk_full
);
    AST_REQ_ABOVE_CUR: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> win_prio > $past(cur_prio)); // R5
    AST_ZERO_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> win_prio != '0); // R9
    AST_VEC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> irq_vec < VEC_W'(NUM_SRC)); // R1
    AST_ACK_LOADS_CUR: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && irq_req && !stk_full) |=> cur_prio == $past(win_prio)); // R7
    AST_ACK_TAKES_VEC: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && irq_req && !stk_full) |=> ack_vec == $past(irq_vec)); // R7
    AST_CUR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_ack && !wr_en) |=> $stable(cur_prio)); // R5
    AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && stk_full && !wr_en) |=> $stable(cur_prio) && $stable(ack_vec)); // R11
endmodule

bind vec_irq_ctrl vic_checker #(
    .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .VEC_W(VEC_W)
) u_vic_checker (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_vec(irq_vec),
    .irq_ack(irq_ack), .ack_vec(ack_vec), .cur_prio(cur_prio), .wr_en(wr_en),
    .win_prio(win_prio_q), .stk_full(stk_full)
);

// File: tb/vec_irq_ctrl_bench.sv
module vec_irq_ctrl_bench;
    import vic_pkg::*;

    localparam int NSRC = 128;
    localparam int NSW  = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC-NSW-1:0] hw_irq = '0;
    logic            wr_en = 1'b0;
    logic [2:0]      wr_kind = '0;
    logic [6:0]      wr_idx = '0;
    logic [3:0]      wr_data = '0;
    logic            irq_ack = 1'b0;
    logic            nmi_in = 1'b0;
    logic            irq_req;
    logic [8:0]      irq_vec;
    logic [8:0]      ack_vec;
    logic [3:0]      cur_prio;
    logic            nmi_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    int m_prio [NSRC];
    bit m_sw [NSW];
    int m_cur = 0;
    int m_stk [$];

    always #2 clk = ~clk;

    vec_irq_ctrl u_vec_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .hw_irq(hw_irq), .wr_en(wr_en),
        .wr_kind(wr_kind), .wr_idx(wr_idx), .wr_data(wr_data),
        .irq_ack(irq_ack), .nmi_in(nmi_in), .irq_req(irq_req),
        .irq_vec(irq_vec), .ack_vec(ack_vec), .cur_prio(cur_prio),
        .nmi_out(nmi_out)
    );

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Winner from the requirement text: highest level, lowest index on ties.
    task automatic ref_win(output int idx, output int p);
        idx = 0; p = 0;
        for (int i = 0; i < NSRC; i++) begin
            bit pend;
            pend = (i < NSW) ? m_sw[i] : hw_irq[i-NSW];
            if (pend && m_prio[i] > p) begin p = m_prio[i]; idx = i; end
        end
    endtask

    task automatic wr(wr_kind_e k, int idx, int data);
        @(negedge clk);
        wr_en = 1'b1; wr_kind = k; wr_idx = 7'(idx); wr_data = 4'(data);
        @(negedge clk);
        wr_en = 1'b0;
        case (k)
            WK_PRIO:  m_prio[idx] = data;
            WK_CUR:   m_cur = data;
            WK_SWSET: m_sw[idx % NSW] = 1'b1;
            WK_SWCLR: m_sw[idx % NSW] = 1'b0;
            WK_EOI:   if (m_stk.size() != 0) m_cur = m_stk.pop_back();
            default:  ;
        endcase
    endtask

    task automatic settle();
        @(negedge clk);
    endtask

    task automatic check_arb(string tag);
        int idx, p;
        ref_win(idx, p);
        chk({tag, " req"}, irq_req, (p > m_cur) ? 1 : 0);
        if (p > m_cur) chk({tag, " vec"}, irq_vec, idx);
    endtask

    task automatic ack();
        int idx, p;
        bit go;
        ref_win(idx, p);
        go = (p > m_cur) && (m_stk.size() < 16);
        @(negedge clk);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
        if (go) begin
            m_stk.push_back(m_cur);
            m_cur = p;
        end
    endtask

    task automatic t_reset();
        chk("R10 reset irq_req", irq_req, 0);
        chk("R10 reset irq_vec", irq_vec, 0);
        chk("R10 reset ack_vec", ack_vec, 0);
        chk("R10 reset cur_prio", cur_prio, 0);
    endtask

    task automatic t_zero_prio();
        @(negedge clk);
        hw_irq[20-NSW] = 1'b1;
        settle(); settle();
        chk("R9 level 0 source silent", irq_req, 0);
    endtask

    task automatic t_basic();
        wr(WK_PRIO, 20, 5); settle();
        check_arb("R3 R1 single source");
        wr(WK_PRIO, 40, 7); settle();
        @(negedge clk);
        hw_irq[40-NSW] = 1'b1;
        #1 chk("R10 no change before edge vec", irq_vec, 20);
        @(negedge clk);
        chk("R10 one edge later vec", irq_vec, 40);
        hw_irq[40-NSW] = 1'b0;
        settle();
        check_arb("R1 back to source 20");
    endtask

    task automatic t_order();
        wr(WK_PRIO, 30, 9);
        @(negedge clk);
        hw_irq[30-NSW] = 1'b1;
        settle();
        check_arb("R4 higher level wins");
        chk("R4 vec 30", irq_vec, 30);
        wr(WK_PRIO, 50, 9);
        @(negedge clk);
        hw_irq[50-NSW] = 1'b1;
        settle();
        chk("R4 tie lowest index", irq_vec, 30);
        wr(WK_PRIO, 127, 10);
        @(negedge clk);
        hw_irq[127-NSW] = 1'b1;
        settle();
        chk("R4 R1 top source wins", irq_vec, 127);
        hw_irq[127-NSW] = 1'b0;
        hw_irq[50-NSW] = 1'b0;
        settle();
        check_arb("R4 after release");
    endtask

    task automatic t_mask();
        wr(WK_CUR, 0, 9); settle();
        chk("R5 equal level masked", irq_req, 0);
        chk("R5 cur_prio loaded", cur_prio, 9);
        wr(WK_CUR, 0, 8); settle();
        chk("R5 level above cur passes", irq_req, 1);
        chk("R5 vec", irq_vec, 30);
        wr(WK_CUR, 0, 0); settle();
    endtask

    task automatic t_sw();
        wr(WK_PRIO, 3, 12);
        wr(WK_SWSET, 3, 0); settle();
        check_arb("R2 flag set");
        chk("R2 flag 3 vec", irq_vec, 3);
        wr(WK_SWCLR, 3, 0); settle();
        chk("R2 flag cleared vec", irq_vec, 30);
    endtask

    task automatic t_nmi();
        wr(WK_CUR, 0, 15); settle();
        chk("R6 masked req", irq_req, 0);
        @(negedge clk);
        nmi_in = 1'b1;
        #1 chk("R6 nmi high", nmi_out, 1);
        @(negedge clk);
        nmi_in = 1'b0;
        #1 chk("R6 nmi low", nmi_out, 0);
        wr(WK_CUR, 0, 0); settle();
    endtask

    task automatic t_ack_eoi();
        ack();
        chk("R7 cur after ack", cur_prio, 9);
        chk("R7 ack_vec", ack_vec, 30);
        settle();
        chk("R7 served source no longer requests", irq_req, 0);
        wr(WK_SWSET, 3, 0); settle();
        chk("R7 preempt req", irq_req, 1);
        chk("R7 preempt vec", irq_vec, 3);
        ack();
        chk("R7 cur nested", cur_prio, 12);
        chk("R7 ack_vec nested", ack_vec, 3);
        wr(WK_SWCLR, 3, 0);
        wr(WK_EOI, 0, 0);
        chk("R8 first pop", cur_prio, 9);
        wr(WK_EOI, 0, 0);
        chk("R8 second pop", cur_prio, 0);
        wr(WK_EOI, 0, 0);
        chk("R8 pop on empty", cur_prio, 0);
        settle();
    endtask

    task automatic t_full();
        for (int k = 0; k < 16; k++) begin
            wr(WK_CUR, 0, k % 9); settle();
            ack();
            chk("R11 push accepted", cur_prio, 9);
            settle();
        end
        wr(WK_PRIO, 60, 11);
        @(negedge clk);
        hw_irq[60-NSW] = 1'b1;
        wr(WK_CUR, 0, 5); settle();
        chk("R11 req while full", irq_req, 1);
        ack();
        chk("R11 full ack cur", cur_prio, 5);
        chk("R11 full ack vec", ack_vec, 30);
        for (int k = 15; k >= 0; k--) begin
            wr(WK_EOI, 0, 0);
            chk("R11 reverse order pop", cur_prio, k % 9);
        end
        wr(WK_EOI, 0, 0);
        chk("R8 pop after drain", cur_prio, 0);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        for (int i = 0; i < NSRC; i++) m_prio[i] = 0;
        for (int i = 0; i < NSW; i++) m_sw[i] = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        settle();
        t_reset();
        t_zero_prio();
        t_basic();
        t_order();
        t_mask();
        t_sw();
        t_nmi();
        t_ack_eoi();
        t_full();
        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            summary();
            $finish;
        end
    end
endmodule